// File: doc/BRIEF.md
# Token-Ring Node Command and Status Register Block

This block sits between a host processor and the transceiver core of a token-passing LAN node. The host writes single command bytes. The low three bits of each byte pick the operation, and the upper bits carry a buffer page number or option flags. The block decodes each byte into one-cycle start pulses and held settings: the transmit page, the receive page with its option bit, and the packet-length option. It also updates the status flags that each command is defined to touch.

The transceiver core reports events as single-cycle pulses: transmission finished (with an acknowledge qualifier), packet received, reconfiguration seen, and power-on reset. These set the matching status flags. The host reads the status byte and programs a mask register. The interrupt line is the registered OR of every enabled pending source. A writable configuration byte and the mask register share the host data bus, each with its own write strobe.

Top module: `lan_cmd_status`

## Requirements
- R1: After reset the status byte is 0x91 (receiver-inhibited bit 7, power-on bit 4 and transmitter-available bit 0 set), the configuration byte is 0x1C, the mask is 0, and the interrupt, start pulses, pages, receive option and long-packet option are all 0.
- R2: A command matching 000n n011 clears status bits 0 and 1, latches nn (bits 4:3) as the transmit page, and raises `tx_go_o` for exactly one cycle.
- R3: `ev_tx_done` sets status bit 0; it sets status bit 1 only when `ev_ack_rx` is high in the same cycle.
- R4: A command matching b00n n100 clears status bit 7, latches nn (bits 4:3) as the receive page and b (bit 7) as the receive option, and raises `rx_go_o` for one cycle.
- R5: `ev_pkt_rx` sets status bit 7 and the receive-pending source.
- R6: A command matching 0000 c101 latches c (bit 3) onto `long_pkt_o`.
- R7: `ev_recon` sets status bit 2 and `ev_por` sets status bit 4; a command matching 000r p110 clears bit 2 when r (bit 4) is 1 and bit 4 when p (bit 3) is 1.
- R8: Command 0x08 clears the receive-pending source and leaves status bit 7 unchanged.
- R9: `intr_o` goes high one cycle after a source is pending and its mask bit is set. Mask bits 4, 2, 1 and 0 enable the status bits of the same position, and mask bit 7 enables receive-pending.
- R10: A command byte matching none of the five encodings changes no status, page, option or configuration state and raises no start pulse.
- R11: In the same cycle, an enable-transmit command wins over `ev_tx_done`, and an enable-receive command or command 0x08 wins over `ev_pkt_rx`. A reconfiguration or power-on event wins over a clear-flags command.
- R12: `cfg_wr` loads `host_data` into the configuration byte and `mask_wr` loads it into the interrupt mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Command byte strobe |
| cfg_wr | input | 1 | Configuration byte write strobe |
| mask_wr | input | 1 | Interrupt mask write strobe |
| host_data | input | 8 | Host write data |
| ev_tx_done | input | 1 | Core: transmission finished |
| ev_ack_rx | input | 1 | Core: acknowledge received, qualifies ev_tx_done |
| ev_pkt_rx | input | 1 | Core: packet received |
| ev_recon | input | 1 | Core: network reconfiguration seen |
| ev_por | input | 1 | Core: power-on reset event |
| status_o | output | 8 | Status byte |
| tx_page_o | output | PAGE_W | Transmit buffer page |
| rx_page_o | output | PAGE_W | Receive buffer page |
| rx_opt_o | output | 1 | Receive option bit |
| long_pkt_o | output | 1 | Packet-length option |
| tx_go_o | output | 1 | Transmit start pulse |
| rx_go_o | output | 1 | Receive start pulse |
| cfg_o | output | 8 | Configuration byte |
| mask_o | output | 8 | Interrupt mask |
| intr_o | output | 1 | Interrupt request |

## Verification
The embedded assertions check on every cycle that decoded commands are mutually exclusive. They also check that an enable-transmit clears the transmit flags, that a finished transmission or a received packet sets its flag, that a reconfiguration event is never lost to a clear, and that an unmatched byte leaves the visible state unchanged. Other behaviour depends on specific byte values and on the order of events, so only the directed scenarios can show it. This covers page and option field extraction, acknowledge-qualified setting of bit 1, selective flag clearing, mask gating with its one-cycle interrupt delay, and the same-cycle priority cases.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned OP_W   = 3;

   localparam logic [OP_W-1:0] OP_TX  = 3'b011;
   localparam logic [OP_W-1:0] OP_RX  = 3'b100;
   localparam logic [OP_W-1:0] OP_CFG = 3'b101;
   localparam logic [OP_W-1:0] OP_CLR = 3'b110;
   localparam logic [BYTE_W-1:0] CMD_RXINT_CLR = 8'h08;

   localparam int unsigned SB_TA    = 0;
   localparam int unsigned SB_TMA   = 1;
   localparam int unsigned SB_RECON = 2;
   localparam int unsigned SB_TEST  = 3;
   localparam int unsigned SB_POR   = 4;
   localparam int unsigned SB_RI    = 7;

   typedef struct packed {
      logic       tx_en;
      logic       rx_en;
      logic       cfg_def;
      logic       clr_flags;
      logic       clr_rxint;
      logic [1:0] page;
      logic       opt;
      logic       long_sel;
      logic       clr_recon;
      logic       clr_por;
   } cmd_t;
endpackage

// File: rtl/lcs_cmd_decode.sv
module lcs_cmd_decode
   import lcs_pkg::*;
(
   input  logic              wr,
   input  logic [BYTE_W-1:0] data,
   output cmd_t              cmd
);
   logic [OP_W-1:0] op;
   logic            hi3_zero;
   logic            mid2_zero;
   logic            hi4_zero;

   assign op        = data[OP_W-1:0];
   assign hi3_zero  = (data[7:5] == 3'b000);
   assign mid2_zero = (data[6:5] == 2'b00);
   assign hi4_zero  = (data[7:4] == 4'b0000);

   always_comb begin
      cmd           = '0;
      cmd.tx_en     = wr && hi3_zero  && (op == OP_TX);
      cmd.rx_en     = wr && mid2_zero && (op == OP_RX);
      cmd.cfg_def   = wr && hi4_zero  && (op == OP_CFG);
      cmd.clr_flags = wr && hi3_zero  && (op == OP_CLR);
      cmd.clr_rxint = wr && (data == CMD_RXINT_CLR);
      cmd.page      = data[4:3];
      cmd.opt       = data[7];
      cmd.long_sel  = data[3];
      cmd.clr_recon = cmd.clr_flags && data[4];
      cmd.clr_por   = cmd.clr_flags && data[3];
   end
endmodule

// File: rtl/lcs_status_flags.sv
module lcs_status_flags
   import lcs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              rx_en,
   input  logic              clr_rxint,
   input  logic              clr_recon,
   input  logic              clr_por,
   input  logic              ev_tx_done,
   input  logic              ev_ack_rx,
   input  logic              ev_pkt_rx,
   input  logic              ev_recon,
   input  logic              ev_por,
   output logic [BYTE_W-1:0] status_o,
   output logic              rx_pend_o
);
   logic ta_q, tma_q, recon_q, por_q, ri_q, rxp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ta_q    <= 1'b1;
         tma_q   <= 1'b0;
         recon_q <= 1'b0;
         por_q   <= 1'b1;
         ri_q    <= 1'b1;
         rxp_q   <= 1'b0;
      end else begin
         if (tx_en)           ta_q <= 1'b0;
         else if (ev_tx_done) ta_q <= 1'b1;

         if (tx_en)                         tma_q <= 1'b0;
         else if (ev_tx_done && ev_ack_rx)  tma_q <= 1'b1;

         if (rx_en)          ri_q <= 1'b0;
         else if (ev_pkt_rx) ri_q <= 1'b1;

         if (rx_en || clr_rxint) rxp_q <= 1'b0;
         else if (ev_pkt_rx)     rxp_q <= 1'b1;

         if (ev_recon)       recon_q <= 1'b1;
         else if (clr_recon) recon_q <= 1'b0;

         if (ev_por)       por_q <= 1'b1;
         else if (clr_por) por_q <= 1'b0;
      end
   end

   always_comb begin
      status_o           = '0;
      status_o[SB_TA]    = ta_q;
      status_o[SB_TMA]   = tma_q;
      status_o[SB_RECON] = recon_q;
      status_o[SB_TEST]  = 1'b0;
      status_o[SB_POR]   = por_q;
      status_o[SB_RI]    = ri_q;
   end
   assign rx_pend_o = rxp_q;

   // R2
   tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en |=> (!ta_q && !tma_q));
   // R3
   tx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_tx_done && !tx_en) |=> ta_q);
   // R5
   rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_pkt_rx && !rx_en && !clr_rxint) |=> (ri_q && rxp_q));
   // R7
   recon_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_recon |=> recon_q);
   // R8
   rxint_ri_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_rxint && !ev_pkt_rx) |=> (!rxp_q && $stable(ri_q)));
endmodule

// File: rtl/lcs_ctl_regs.sv
module lcs_ctl_regs
   import lcs_pkg::*;
#(
   parameter int unsigned        PAGE_W    = 2,
   parameter logic [BYTE_W-1:0]  CFG_RESET = 8'h1C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              rx_en,
   input  logic              cfg_def,
   input  logic [1:0]        page,
   input  logic              opt,
   input  logic              long_sel,
   input  logic              cfg_wr,
   input  logic              mask_wr,
   input  logic [BYTE_W-1:0] data,
   output logic [PAGE_W-1:0] tx_page_o,
   output logic [PAGE_W-1:0] rx_page_o,
   output logic              rx_opt_o,
   output logic              long_pkt_o,
   output logic              tx_go_o,
   output logic              rx_go_o,
   output logic [BYTE_W-1:0] cfg_o,
   output logic [BYTE_W-1:0] mask_o
);
   logic [PAGE_W-1:0] page_sel;

   generate
      if (PAGE_W == 2) begin : g_full_page
         assign page_sel = page;
      end else begin : g_narrow_page
         logic unused_hi;
         assign unused_hi = page[1];
         assign page_sel  = page[PAGE_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_page_o  <= '0;
         rx_page_o  <= '0;
         rx_opt_o   <= 1'b0;
         long_pkt_o <= 1'b0;
         tx_go_o    <= 1'b0;
         rx_go_o    <= 1'b0;
         cfg_o      <= CFG_RESET;
         mask_o     <= '0;
      end else begin
         tx_go_o <= tx_en;
         rx_go_o <= rx_en;
         if (tx_en) tx_page_o <= page_sel;
         if (rx_en) begin
            rx_page_o <= page_sel;
            rx_opt_o  <= opt;
         end
         if (cfg_def) long_pkt_o <= long_sel;
         if (cfg_wr)  cfg_o      <= data;
         if (mask_wr) mask_o     <= data;
      end
   end

   // R2
   tx_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en |=> (tx_go_o && tx_page_o == $past(page_sel)));
   // R4
   rx_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_en |=> (rx_go_o && rx_opt_o == $past(opt)));
endmodule

// File: rtl/lan_cmd_status.sv
module lan_cmd_status
   import lcs_pkg::*;
#(
   parameter int unsigned       PAGE_W    = 2,
   parameter logic [7:0]        CFG_RESET = 8'h1C,
   parameter bit                IRQ_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              cfg_wr,
   input  logic              mask_wr,
   input  logic [7:0]        host_data,
   input  logic              ev_tx_done,
   input  logic              ev_ack_rx,
   input  logic              ev_pkt_rx,
   input  logic              ev_recon,
   input  logic              ev_por,
   output logic [7:0]        status_o,
   output logic [PAGE_W-1:0] tx_page_o,
   output logic [PAGE_W-1:0] rx_page_o,
   output logic              rx_opt_o,
   output logic              long_pkt_o,
   output logic              tx_go_o,
   output logic              rx_go_o,
   output logic [7:0]        cfg_o,
   output logic [7:0]        mask_o,
   output logic              intr_o
);
   generate
      if (PAGE_W < 1 || PAGE_W > 2) begin : g_bad_page_w
         $error("PAGE_W must be 1 or 2: the page field is two bits of the command");
      end
   endgenerate

   cmd_t              cmd;
   logic              rx_pend;
   logic [BYTE_W-1:0] irq_src;
   logic              irq_any;

   lcs_cmd_decode u_dec (
      .wr   (host_wr),
      .data (host_data),
      .cmd  (cmd)
   );

   lcs_status_flags u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_en      (cmd.tx_en),
      .rx_en      (cmd.rx_en),
      .clr_rxint  (cmd.clr_rxint),
      .clr_recon  (cmd.clr_recon),
      .clr_por    (cmd.clr_por),
      .ev_tx_done (ev_tx_done),
      .ev_ack_rx  (ev_ack_rx),
      .ev_pkt_rx  (ev_pkt_rx),
      .ev_recon   (ev_recon),
      .ev_por     (ev_por),
      .status_o   (status_o),
      .rx_pend_o  (rx_pend)
   );

   lcs_ctl_regs #(.PAGE_W(PAGE_W), .CFG_RESET(CFG_RESET)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_en      (cmd.tx_en),
      .rx_en      (cmd.rx_en),
      .cfg_def    (cmd.cfg_def),
      .page       (cmd.page),
      .opt        (cmd.opt),
      .long_sel   (cmd.long_sel),
      .cfg_wr     (cfg_wr),
      .mask_wr    (mask_wr),
      .data       (host_data),
      .tx_page_o  (tx_page_o),
      .rx_page_o  (rx_page_o),
      .rx_opt_o   (rx_opt_o),
      .long_pkt_o (long_pkt_o),
      .tx_go_o    (tx_go_o),
      .rx_go_o    (rx_go_o),
      .cfg_o      (cfg_o),
      .mask_o     (mask_o)
   );

   always_comb begin
      irq_src          = status_o;
      irq_src[SB_RI]   = rx_pend;
      irq_src[SB_TEST] = 1'b0;
   end
   assign irq_any = |(irq_src & mask_o);

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic intr_q;
         always_ff @(posedge clk) begin
            if (!rst_n) intr_q <= 1'b0;
            else        intr_q <= irq_any;
         end
         assign intr_o = intr_q;
      end else begin : g_irq_comb
         assign intr_o = irq_any;
      end
   endgenerate

   // R10
   cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd.tx_en, cmd.rx_en, cmd.cfg_def, cmd.clr_flags, cmd.clr_rxint}));
   // R10
   ignored_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !cfg_wr && !mask_wr &&
       !(cmd.tx_en || cmd.rx_en || cmd.cfg_def || cmd.clr_flags || cmd.clr_rxint) &&
       !(ev_tx_done || ev_pkt_rx || ev_recon || ev_por))
      |=> ($stable(status_o) && $stable(cfg_o) && $stable(long_pkt_o) && !tx_go_o && !rx_go_o));
endmodule

// File: tb/lan_cmd_status_tb_top.sv
module lan_cmd_status_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr = 1'b0, cfg_wr = 1'b0, mask_wr = 1'b0;
   logic [7:0] host_data = '0;
   logic       ev_tx_done = 1'b0, ev_ack_rx = 1'b0, ev_pkt_rx = 1'b0, ev_recon = 1'b0, ev_por = 1'b0;
   logic [7:0] status_o, cfg_o, mask_o;
   logic [1:0] tx_page_o, rx_page_o;
   logic       rx_opt_o, long_pkt_o, tx_go_o, rx_go_o, intr_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   lan_cmd_status dut_i (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .cfg_wr(cfg_wr), .mask_wr(mask_wr),
      .host_data(host_data), .ev_tx_done(ev_tx_done), .ev_ack_rx(ev_ack_rx),
      .ev_pkt_rx(ev_pkt_rx), .ev_recon(ev_recon), .ev_por(ev_por),
      .status_o(status_o), .tx_page_o(tx_page_o), .rx_page_o(rx_page_o),
      .rx_opt_o(rx_opt_o), .long_pkt_o(long_pkt_o), .tx_go_o(tx_go_o), .rx_go_o(rx_go_o),
      .cfg_o(cfg_o), .mask_o(mask_o), .intr_o(intr_o)
   );

   task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // ev = {por, recon, pkt, ack, done}
   task automatic cyc(input logic hw, input logic cw, input logic mw, input logic [7:0] d, input logic [4:0] ev);
      @(negedge clk);
      host_wr = hw; cfg_wr = cw; mask_wr = mw; host_data = d;
      {ev_por, ev_recon, ev_pkt_rx, ev_ack_rx, ev_tx_done} = ev;
      @(negedge clk);
      host_wr = 1'b0; cfg_wr = 1'b0; mask_wr = 1'b0; host_data = '0;
      {ev_por, ev_recon, ev_pkt_rx, ev_ack_rx, ev_tx_done} = '0;
   endtask

   task automatic cmd(input logic [7:0] d);
      cyc(1'b1, 1'b0, 1'b0, d, 5'b0);
   endtask

   task automatic ev(input logic [4:0] e);
      cyc(1'b0, 1'b0, 1'b0, 8'h00, e);
   endtask

   task automatic t_reset();
      check("R1", "status", status_o, 8'h91);
      check("R1", "cfg", cfg_o, 8'h1C);
      check("R1", "mask", mask_o, 8'h00);
      check("R1", "intr/go/long/opt", {4'b0, intr_o, tx_go_o, rx_go_o, long_pkt_o}, 8'h00);
      check("R1", "pages/opt", {3'b0, rx_opt_o, tx_page_o, rx_page_o}, 8'h00);
   endtask

   task automatic t_transmit();
      cmd(8'h1B);
      check("R2", "status after tx cmd", status_o, 8'h90);
      check("R2", "tx_page", {6'b0, tx_page_o}, 8'h03);
      check("R2", "tx_go pulse", {7'b0, tx_go_o}, 8'h01);
      @(negedge clk);
      check("R2", "tx_go one cycle", {7'b0, tx_go_o}, 8'h00);
      ev(5'b00001);
      check("R3", "done without ack", status_o, 8'h91);
      cmd(8'h0B);
      check("R2", "tx_page 1", {6'b0, tx_page_o}, 8'h01);
      ev(5'b00010);
      check("R3", "ack alone ignored", status_o, 8'h90);
      ev(5'b00011);
      check("R3", "done with ack", status_o, 8'h93);
   endtask

   task automatic t_receive();
      cmd(8'h94);
      check("R4", "RI cleared", status_o, 8'h13);
      check("R4", "rx page/opt/go", {4'b0, rx_opt_o, rx_go_o, rx_page_o}, 8'h0E);
      cmd(8'h0C);
      check("R4", "rx page 1, opt 0", {5'b0, rx_opt_o, rx_page_o}, 8'h01);
      ev(5'b00100);
      check("R5", "RI set by packet", status_o, 8'h93);
   endtask

   task automatic t_config();
      cmd(8'h0D);
      check("R6", "long option set", {7'b0, long_pkt_o}, 8'h01);
      cmd(8'h05);
      check("R6", "long option clear", {7'b0, long_pkt_o}, 8'h00);
      cyc(1'b0, 1'b1, 1'b0, 8'h5A, 5'b0);
      check("R12", "cfg write", cfg_o, 8'h5A);
      cyc(1'b0, 1'b0, 1'b1, 8'h00, 5'b0);
      check("R12", "mask write", mask_o, 8'h00);
   endtask

   task automatic t_flags();
      ev(5'b01000);
      check("R7", "recon set", status_o, 8'h97);
      cmd(8'h16);
      check("R7", "clear recon only", status_o, 8'h93);
      cmd(8'h0E);
      check("R7", "clear por only", status_o, 8'h83);
      ev(5'b10000);
      check("R7", "por set", status_o, 8'h93);
      cmd(8'h1E);
      check("R7", "clear both", status_o, 8'h83);
   endtask

   task automatic t_irq();
      // receive-pending is set from t_receive
      cyc(1'b0, 1'b0, 1'b1, 8'h80, 5'b0);
      check("R9", "intr one cycle after mask", {7'b0, intr_o}, 8'h00);
      @(negedge clk);
      check("R9", "intr rx pending", {7'b0, intr_o}, 8'h01);
      cmd(8'h08);
      check("R8", "RI unchanged by 0x08", {7'b0, status_o[7]}, 8'h01);
      @(negedge clk);
      check("R8", "intr drops after 0x08", {7'b0, intr_o}, 8'h00);
      cyc(1'b0, 1'b0, 1'b1, 8'h04, 5'b0);
      @(negedge clk);
      check("R9", "masked-off TA does not interrupt", {7'b0, intr_o}, 8'h00);
      ev(5'b01000);
      @(negedge clk);
      check("R9", "recon interrupt", {7'b0, intr_o}, 8'h01);
      cmd(8'h16);
      @(negedge clk);
      check("R9", "intr clears with flag", {7'b0, intr_o}, 8'h00);
      cyc(1'b0, 1'b0, 1'b1, 8'h00, 5'b0);
   endtask

   task automatic t_ignore();
      logic [7:0] s0, c0;
      logic [5:0] p0;
      s0 = status_o; c0 = cfg_o;
      p0 = {tx_page_o, rx_page_o, rx_opt_o, long_pkt_o};
      foreach (s0[i]) begin end
      cmd(8'hFF);
      check("R10", "status after 0xFF", status_o, s0);
      check("R10", "go after 0xFF", {6'b0, tx_go_o, rx_go_o}, 8'h00);
      cmd(8'h23);
      cmd(8'h48);
      cmd(8'h07);
      cmd(8'hE3);
      check("R10", "status after bad bytes", status_o, s0);
      check("R10", "cfg after bad bytes", cfg_o, c0);
      check("R10", "pages/options unchanged", {2'b0, tx_page_o, rx_page_o, rx_opt_o, long_pkt_o}, {2'b0, p0});
   endtask

   task automatic t_priority();
      // status is 0x83 here: TA=1
      cyc(1'b1, 1'b0, 1'b0, 8'h03, 5'b00001);
      check("R11", "tx cmd beats tx_done", {7'b0, status_o[0]}, 8'h00);
      cyc(1'b1, 1'b0, 1'b0, 8'h16, 5'b01000);
      check("R11", "recon event beats clear", {7'b0, status_o[2]}, 8'h01);
      cyc(1'b1, 1'b0, 1'b0, 8'h04, 5'b00100);
      check("R11", "rx cmd beats packet", {7'b0, status_o[7]}, 8'h00);
      cyc(1'b1, 1'b0, 1'b0, 8'h08, 5'b00100);
      cyc(1'b0, 1'b0, 1'b1, 8'h80, 5'b0);
      @(negedge clk);
      check("R11", "0x08 beats packet for pending", {7'b0, intr_o}, 8'h00);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_transmit();
      t_receive();
      t_config();
      t_flags();
      t_irq();
      t_ignore();
      t_priority();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule